// File: doc/BRIEF.md
# SDRAM Open-Row Access Sequencer

This block sits between a bus master and the command port of a synchronous DRAM. For every access it accepts for the SDRAM space, it decides which commands to send. If the wanted bank and row are already active, it sends only the read or write command. Otherwise it sends a full sequence: an optional precharge, an activate, and then the read or write. It remembers a single open row. That row stays open while the bus serves other address spaces, so the row can be reused when SDRAM traffic resumes.

Row keeping is governed by one enable input and by nothing else. With the enable low, every access is a full one, and the row is closed again after the access. A fixed set of system events (refresh, self-refresh entry, standby entry, release of the external bus, a write of the SDRAM mode register, and the enable going low) discards the remembered row. The next SDRAM access is then a full one. The master is held off through `req_ready` while a multi-command sequence runs.

Top module: `sdram_openrow_seq`

## Requirements
- R1: After reset `cmd_valid` is 0, `cmd_code` is 0, `req_ready` is 1, and no row is recorded as open.
- R2: With `keep_open_en` at 1 and the recorded row matching the bank and row of an accepted SDRAM access, the only command is READ or WRITE. It appears in the cycle after acceptance, and `req_ready` stays 1.
- R3: An accepted SDRAM access that misses while a row is recorded as open produces three commands in consecutive cycles starting the cycle after acceptance: PRE (previous bank, address 0), then ACTV (new bank, row), then READ/WRITE (new bank, column). `req_ready` is 0 in the first two of those cycles.
- R4: An accepted SDRAM access with no row recorded produces ACTV then READ/WRITE on the two cycles after acceptance, with `req_ready` 0 in the first.
- R5: With `keep_open_en` at 0, each SDRAM access produces ACTV, READ/WRITE, PRE (same bank, address 0) on three consecutive cycles, and no row is recorded afterwards.
- R6: A one-cycle pulse on `ev_refresh`, `ev_self_refresh` or `ev_standby` makes the next SDRAM access a full access without PRE.
- R7: A one-cycle pulse on `ev_bus_release` or `ev_mode_write` makes the next SDRAM access a full access without PRE.
- R8: A 1-to-0 change of `keep_open_en` discards the recorded row, even if the enable returns to 1 before the next access.
- R9: An event in the same cycle as an accepted SDRAM access takes priority. That access is a full access without PRE, and no row is recorded from it.
- R10: An accepted access whose `req_space` differs from the SDRAM space value (default 2) issues no command and leaves the recorded row unchanged.
- R11: Command codes are NOP=0, ACTV=1, READ=2, WRITE=3, PRE=4. Each command is valid for one clock. `cmd_code`, `cmd_bank` and `cmd_addr` are 0 when `cmd_valid` is 0. Row and column are zero-extended onto `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_space | input | SPACE_W | Address space of the request |
| req_bank | input | BANK_W | SDRAM bank |
| req_row | input | ROW_W | SDRAM row |
| req_col | input | COL_W | SDRAM column |
| req_write | input | 1 | 1 = write, 0 = read |
| keep_open_en | input | 1 | Keep rows open between accesses |
| ev_refresh | input | 1 | Refresh started |
| ev_self_refresh | input | 1 | Self-refresh entered |
| ev_standby | input | 1 | Standby entered |
| ev_bus_release | input | 1 | External bus released to another master |
| ev_mode_write | input | 1 | SDRAM mode register written |
| cmd_valid | output | 1 | Command present this cycle |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | BANK_W | Command bank |
| cmd_addr | output | max(ROW_W,COL_W) | Row for ACTV, column for READ/WRITE, 0 for PRE |

## Verification
The assertions assume that each event strobe is a single-cycle pulse. They also assume that request fields only count in a cycle where both `req_valid` and `req_ready` are high, and that the first command after acceptance depends only on that cycle's inputs. The stimulus drives inputs on the falling edge and pulses each event for exactly one clock. It holds a request for one cycle, and only after `req_ready` is seen high. A randomised phase mixes spaces, a small set of rows and occasional events, so that hits, misses and event collisions all occur.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_ACTV  = 3'd1,
      CMD_READ  = 3'd2,
      CMD_WRITE = 3'd3,
      CMD_PRE   = 3'd4
   } sdr_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACTV,
      ST_RW,
      ST_CLOSE
   } seq_state_e;

   localparam int unsigned NUM_EVENTS = 5;

   function automatic int unsigned wider(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdr_inval_merge.sv
module sdr_inval_merge #(
   parameter int unsigned      N_EV    = 5,
   parameter logic [N_EV-1:0]  EV_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            keep_en,
   input  logic [N_EV-1:0] ev,
   output logic            kill
);

   logic            en_q;
   logic [N_EV-1:0] gated;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= keep_en;
   end

   for (genvar i = 0; i < N_EV; i++) begin : g_ev
      if (EV_MASK[i]) begin : g_on
         assign gated[i] = ev[i];
      end else begin : g_off
         assign gated[i] = 1'b0;
      end
   end

   assign kill = (|gated) | (en_q & ~keep_en);

endmodule

// File: rtl/sdr_row_tracker.sv
module sdr_row_tracker #(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned ROW_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill,
   input  logic              set,
   input  logic [BANK_W-1:0] new_bank,
   input  logic [ROW_W-1:0]  new_row,
   output logic              open_vld,
   output logic [BANK_W-1:0] open_bank,
   output logic              hit
);

   logic              vld_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         bank_q <= '0;
         row_q  <= '0;
      end else if (kill) begin
         vld_q  <= 1'b0;
      end else if (set) begin
         vld_q  <= 1'b1;
         bank_q <= new_bank;
         row_q  <= new_row;
      end
   end

   assign open_vld  = vld_q & ~kill;
   assign open_bank = bank_q;
   assign hit       = open_vld && (bank_q == new_bank) && (row_q == new_row);

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
   import sdr_seq_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned ROW_W  = 13,
   parameter int unsigned COL_W  = 10,
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              keep_en,
   input  logic              hit,
   input  logic              pre_first,
   input  logic [BANK_W-1:0] old_bank,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [COL_W-1:0]  in_col,
   input  logic              in_wr,
   output logic              idle,
   output logic              cmd_valid,
   output sdr_cmd_e          cmd_code,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ADDR_W-1:0] cmd_addr
);

   seq_state_e        state_q, state_d;
   logic [BANK_W-1:0] bank_q, bank_d;
   logic [ROW_W-1:0]  row_q, row_d;
   logic [COL_W-1:0]  col_q, col_d;
   logic              wr_q, wr_d;
   logic              close_q, close_d;
   sdr_cmd_e          code_d;
   logic [BANK_W-1:0] cbank_d;
   logic [ADDR_W-1:0] caddr_d;

   always_comb begin
      state_d = state_q;
      bank_d  = bank_q;
      row_d   = row_q;
      col_d   = col_q;
      wr_d    = wr_q;
      close_d = close_q;
      code_d  = CMD_NOP;
      cbank_d = '0;
      caddr_d = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               bank_d  = in_bank;
               row_d   = in_row;
               col_d   = in_col;
               wr_d    = in_wr;
               close_d = ~keep_en;
               if (hit) begin
                  code_d  = in_wr ? CMD_WRITE : CMD_READ;
                  cbank_d = in_bank;
                  caddr_d[COL_W-1:0] = in_col;
               end else if (pre_first) begin
                  code_d  = CMD_PRE;
                  cbank_d = old_bank;
                  state_d = ST_ACTV;
               end else begin
                  code_d  = CMD_ACTV;
                  cbank_d = in_bank;
                  caddr_d[ROW_W-1:0] = in_row;
                  state_d = ST_RW;
               end
            end
         end
         ST_ACTV: begin
            code_d  = CMD_ACTV;
            cbank_d = bank_q;
            caddr_d[ROW_W-1:0] = row_q;
            state_d = ST_RW;
         end
         ST_RW: begin
            code_d  = wr_q ? CMD_WRITE : CMD_READ;
            cbank_d = bank_q;
            caddr_d[COL_W-1:0] = col_q;
            state_d = close_q ? ST_CLOSE : ST_IDLE;
         end
         ST_CLOSE: begin
            code_d  = CMD_PRE;
            cbank_d = bank_q;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bank_q    <= '0;
         row_q     <= '0;
         col_q     <= '0;
         wr_q      <= 1'b0;
         close_q   <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_code  <= CMD_NOP;
         cmd_bank  <= '0;
         cmd_addr  <= '0;
      end else begin
         state_q   <= state_d;
         bank_q    <= bank_d;
         row_q     <= row_d;
         col_q     <= col_d;
         wr_q      <= wr_d;
         close_q   <= close_d;
         cmd_valid <= (code_d != CMD_NOP);
         cmd_code  <= code_d;
         cmd_bank  <= cbank_d;
         cmd_addr  <= caddr_d;
      end
   end

   assign idle = (state_q == ST_IDLE);

endmodule

// File: rtl/sdram_openrow_seq.sv
module sdram_openrow_seq
   import sdr_seq_pkg::*;
#(
   parameter int unsigned              BANK_W      = 2,
   parameter int unsigned              ROW_W       = 13,
   parameter int unsigned              COL_W       = 10,
   parameter int unsigned              SPACE_W     = 3,
   parameter logic [SPACE_W-1:0]       SDRAM_SPACE = SPACE_W'(2),
   parameter logic [NUM_EVENTS-1:0]    INVAL_MASK  = '1,
   localparam int unsigned             ADDR_W      = wider(ROW_W, COL_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SPACE_W-1:0] req_space,
   input  logic [BANK_W-1:0]  req_bank,
   input  logic [ROW_W-1:0]   req_row,
   input  logic [COL_W-1:0]   req_col,
   input  logic               req_write,
   input  logic               keep_open_en,
   input  logic               ev_refresh,
   input  logic               ev_self_refresh,
   input  logic               ev_standby,
   input  logic               ev_bus_release,
   input  logic               ev_mode_write,
   output logic               cmd_valid,
   output logic [2:0]         cmd_code,
   output logic [BANK_W-1:0]  cmd_bank,
   output logic [ADDR_W-1:0]  cmd_addr
);

   if (BANK_W < 1 || ROW_W < 1 || COL_W < 1) begin : g_bad_addr
      $error("sdram_openrow_seq: bank, row and column widths must be at least 1");
   end
   if (SPACE_W < 1) begin : g_bad_space
      $error("sdram_openrow_seq: SPACE_W must be at least 1");
   end

   logic [NUM_EVENTS-1:0] ev_vec;
   logic                  kill;
   logic                  accept;
   logic                  is_sdram;
   logic                  start;
   logic                  open_vld;
   logic [BANK_W-1:0]     open_bank;
   logic                  trk_hit;
   logic                  seq_idle;
   sdr_cmd_e              code_e;

   assign ev_vec   = {ev_mode_write, ev_bus_release, ev_standby, ev_self_refresh, ev_refresh};
   assign req_ready = seq_idle;
   assign accept   = req_valid & req_ready;
   assign is_sdram = (req_space == SDRAM_SPACE);
   assign start    = accept & is_sdram;

   sdr_inval_merge #(
      .N_EV    (NUM_EVENTS),
      .EV_MASK (INVAL_MASK)
   ) u_inval (
      .clk     (clk),
      .rst_n   (rst_n),
      .keep_en (keep_open_en),
      .ev      (ev_vec),
      .kill    (kill)
   );

   sdr_row_tracker #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .kill      (kill),
      .set       (start & keep_open_en),
      .new_bank  (req_bank),
      .new_row   (req_row),
      .open_vld  (open_vld),
      .open_bank (open_bank),
      .hit       (trk_hit)
   );

   sdr_cmd_seq #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .keep_en   (keep_open_en),
      .hit       (trk_hit & keep_open_en),
      .pre_first (open_vld),
      .old_bank  (open_bank),
      .in_bank   (req_bank),
      .in_row    (req_row),
      .in_col    (req_col),
      .in_wr     (req_write),
      .idle      (seq_idle),
      .cmd_valid (cmd_valid),
      .cmd_code  (code_e),
      .cmd_bank  (cmd_bank),
      .cmd_addr  (cmd_addr)
   );

   assign cmd_code = code_e;

endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
   parameter int unsigned        SPACE_W     = 3,
   parameter logic [SPACE_W-1:0] SDRAM_SPACE = SPACE_W'(2)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [SPACE_W-1:0] req_space,
   input logic               keep_open_en,
   input logic               ev_refresh,
   input logic               ev_self_refresh,
   input logic               ev_standby,
   input logic               ev_bus_release,
   input logic               ev_mode_write,
   input logic               cmd_valid,
   input logic [2:0]         cmd_code
);

   localparam logic [2:0] C_ACTV  = 3'd1;
   localparam logic [2:0] C_READ  = 3'd2;
   localparam logic [2:0] C_WRITE = 3'd3;
   localparam logic [2:0] C_PRE   = 3'd4;

   logic sdr_acc, other_acc, any_ev;
   assign sdr_acc   = req_valid && req_ready && (req_space == SDRAM_SPACE);
   assign other_acc = req_valid && req_ready && (req_space != SDRAM_SPACE);
   assign any_ev    = ev_refresh | ev_self_refresh | ev_standby | ev_bus_release | ev_mode_write;

   p_nop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (cmd_code == 3'd0));

   p_actv_then_rw_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == C_ACTV) |=>
         (cmd_valid && (cmd_code == C_READ || cmd_code == C_WRITE)));

   p_pre_then_actv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == C_PRE && !req_ready) |=> (cmd_valid && cmd_code == C_ACTV));

   p_event_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sdr_acc && any_ev) |=> (cmd_valid && cmd_code == C_ACTV));

   p_disabled_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sdr_acc && !keep_open_en) |=> (cmd_valid && cmd_code == C_ACTV));

   p_other_space_r10: assert property (@(posedge clk) disable iff (!rst_n)
      other_acc |=> !cmd_valid);

endmodule

bind sdram_openrow_seq sdr_seq_checker #(
   .SPACE_W     (SPACE_W),
   .SDRAM_SPACE (SDRAM_SPACE)
) u_chk (.*);

// File: tb/test_sdram_openrow_seq.sv
`timescale 1ns/1ps
module test_sdram_openrow_seq;

   localparam int BW = 2;
   localparam int RW = 13;
   localparam int CW = 10;
   localparam int SW = 3;
   localparam int AW = 13;
   localparam int SDR = 2;
   // R11 encodings
   localparam int K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [SW-1:0] req_space;
   logic [BW-1:0] req_bank;
   logic [RW-1:0] req_row;
   logic [CW-1:0] req_col;
   logic          req_write;
   logic          keep_open_en;
   logic [4:0]    ev;
   logic          cmd_valid;
   logic [2:0]    cmd_code;
   logic [BW-1:0] cmd_bank;
   logic [AW-1:0] cmd_addr;

   always #2.5 clk = ~clk;

   sdram_openrow_seq i_sdram_openrow_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_space(req_space), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_write(req_write), .keep_open_en(keep_open_en),
      .ev_refresh(ev[0]), .ev_self_refresh(ev[1]), .ev_standby(ev[2]),
      .ev_bus_release(ev[3]), .ev_mode_write(ev[4]),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr));

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   // behavioural reference model
   int q[$];
   int m_valid, m_bank, m_row, en_prev;
   int exp_code, exp_bank, exp_addr, exp_ready;

   function automatic int pack(int code, int bank, int addr);
      return (code << 24) | (bank << 16) | addr;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_valid = 0; m_bank = 0; m_row = 0; en_prev = 0;
         exp_code = K_NOP; exp_bank = 0; exp_addr = 0; exp_ready = 1;
      end else begin
         int acc, kill, sdr, hit, e;
         acc  = (req_valid && exp_ready) ? 1 : 0;
         sdr  = (int'(req_space) == SDR) ? 1 : 0;
         kill = ((ev != 0) || (en_prev != 0 && !keep_open_en)) ? 1 : 0;
         if (acc && sdr) begin
            hit = (keep_open_en && m_valid && !kill &&
                   int'(req_bank) == m_bank && int'(req_row) == m_row) ? 1 : 0;
            if (hit) q.push_back(pack(req_write ? K_WR : K_RD, req_bank, req_col));
            else begin
               if (m_valid && !kill) q.push_back(pack(K_PRE, m_bank, 0));
               q.push_back(pack(K_ACT, req_bank, req_row));
               q.push_back(pack(req_write ? K_WR : K_RD, req_bank, req_col));
               if (!keep_open_en) q.push_back(pack(K_PRE, req_bank, 0));
            end
         end
         if (kill) m_valid = 0;
         else if (acc && sdr && keep_open_en) begin
            m_valid = 1; m_bank = req_bank; m_row = req_row;
         end
         en_prev = keep_open_en ? 1 : 0;
         if (q.size() > 0) begin
            e = q.pop_front();
            exp_code = (e >> 24) & 255; exp_bank = (e >> 16) & 255; exp_addr = e & 65535;
         end else begin
            exp_code = K_NOP; exp_bank = 0; exp_addr = 0;
         end
         exp_ready = (q.size() == 0) ? 1 : 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if (int'(cmd_code) != exp_code || int'(cmd_bank) != exp_bank ||
             int'(cmd_addr) != exp_addr || int'(req_ready) != exp_ready ||
             int'(cmd_valid) != (exp_code != K_NOP ? 1 : 0)) begin
            n_bad++;
            $display("FAIL %s: actual v=%0d code=%0d bank=%0d addr=%0d rdy=%0d expected code=%0d bank=%0d addr=%0d rdy=%0d",
                     cur_req, cmd_valid, cmd_code, cmd_bank, cmd_addr, req_ready,
                     exp_code, exp_bank, exp_addr, exp_ready);
         end
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(int sp, int b, int r, int c, int w);
      while (!req_ready) @(negedge clk);
      req_space = SW'(sp); req_bank = BW'(b); req_row = RW'(r); req_col = CW'(c);
      req_write = w[0]; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse(int idx);
      ev[idx] = 1'b1;
      @(negedge clk);
      ev = '0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      finish_run();
   end

   initial begin
      rst_n = 0; req_valid = 0; req_space = 0; req_bank = 0; req_row = 0;
      req_col = 0; req_write = 0; keep_open_en = 0; ev = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      n_cmp++;
      if (cmd_valid !== 1'b0 || cmd_code !== 3'd0 || req_ready !== 1'b1) begin
         n_bad++;
         $display("FAIL R1: actual v=%0d code=%0d rdy=%0d expected 0 0 1", cmd_valid, cmd_code, req_ready);
      end
      rst_n = 1;
      keep_open_en = 1;
      idle(2);

      cur_req = "R4"; issue(SDR, 1, 100, 5, 0); idle(4);
      cur_req = "R2"; issue(SDR, 1, 100, 7, 1); issue(SDR, 1, 100, 8, 0);
      issue(SDR, 1, 100, 1023, 1); idle(3);
      cur_req = "R3"; issue(SDR, 2, 50, 3, 0); idle(4);
      issue(SDR, 2, 8191, 9, 1); idle(4);
      cur_req = "R10"; issue(0, 3, 7, 7, 1); issue(5, 0, 1, 1, 0); idle(2);
      issue(SDR, 2, 8191, 4, 0); idle(3);

      cur_req = "R6";
      for (int i = 0; i < 3; i++) begin
         pulse(i); idle(1); issue(SDR, 2, 8191, i, 0); idle(4);
         issue(SDR, 2, 8191, i, 1); idle(2);
      end
      cur_req = "R7";
      for (int i = 3; i < 5; i++) begin
         pulse(i); idle(1); issue(SDR, 2, 8191, i, 0); idle(4);
         issue(SDR, 2, 8191, i, 1); idle(2);
      end

      cur_req = "R9";
      ev[0] = 1'b1; issue(SDR, 0, 12, 2, 1); ev = '0; idle(4);
      issue(SDR, 0, 12, 3, 0); idle(4);
      ev[3] = 1'b1; issue(SDR, 1, 13, 2, 0); ev = '0; idle(4);

      cur_req = "R8";
      issue(SDR, 3, 77, 1, 0); idle(4);
      keep_open_en = 0; @(negedge clk); keep_open_en = 1; idle(1);
      issue(SDR, 3, 77, 2, 0); idle(4);

      cur_req = "R5";
      keep_open_en = 0; idle(1);
      issue(SDR, 1, 5, 6, 1); issue(SDR, 1, 5, 6, 0); idle(5);
      keep_open_en = 1; idle(1);
      issue(SDR, 1, 5, 6, 0); idle(4);

      cur_req = "R11";
      for (int i = 0; i < 300; i++) begin
         int sp, b, r, c;
         sp = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : SDR;
         b  = $urandom_range(0, 1);
         r  = $urandom_range(0, 2);
         c  = $urandom_range(0, 1023);
         if ($urandom_range(0, 9) == 0) ev[$urandom_range(0, 4)] = 1'b1;
         if ($urandom_range(0, 19) == 0) keep_open_en = ~keep_open_en;
         issue(sp, b, r, c, $urandom_range(0, 1));
         ev = '0;
         idle($urandom_range(0, 2));
      end
      keep_open_en = 1;
      idle(8);
      finish_run();
   end

endmodule